// File: doc/BRIEF.md
# Banked UART Host Register Front-End

This block is the processor-side register decoder of an enhanced UART whose registers are spread over several banks. It decodes a small byte-wide bus (address, read strobe, write strobe, write data, bank number) and a DMA read/write acknowledge pair. It steers data-port traffic to the holding registers or to shallow transmit and receive FIFOs. It keeps the interrupt enable register and masks its upper nibble by operating mode. It also produces the interrupt identification code and a level interrupt output.

The serial side is only modelled as a byte interface. The receive shifter pushes bytes with `rx_push`. The transmit shifter takes bytes with `tx_pop`. Line-status and modem-status conditions arrive as pending levels from outside. Read data is combinational: it is valid in the same cycle as the strobe, and any pop takes effect at the next clock edge.

Top module: `uart_bank_regs`

## Requirements
- R1: After reset the interrupt enable register reads 00h, `irq` is low, `iid` is 0001 (nothing pending), `tx_avail` is low and `tx_ovr` is low.
- R2: With `fifo_en` low, a CPU write to offset 0 in bank 0 loads a single transmit holding byte. That byte appears on `tx_data` with `tx_avail` high until `tx_pop`. A byte delivered by `rx_push` is returned by a CPU read of offset 0.
- R3: With `fifo_en` high, data-port writes are pushed into a transmit FIFO and data-port reads pop a receive FIFO, both oldest first, each up to DEPTH bytes.
- R4: Offsets 0 and 1 are decoded only when `bank` is 0. In other banks CPU accesses there leave the data ports and the enable register untouched and read 00h. DMA reads and writes reach the data port whatever `bank` holds.
- R5: A write to offset 1 in bank 0 stores all eight enable bits when `ext_mode` is high. It stores only bits 3..0 (bits 7..4 become 0) when `ext_mode` is low. Bits 7..4 also clear while `ext_mode` is low, and a read of offset 1 returns the stored value.
- R6: `iid` gives the highest-priority enabled pending source, in this order: line status (enable bit 2) 0110, receive data level (bit 0) 0100, receive time-out (bit 0) 1100, transmit low level (bit 1) 0010, modem status (bit 3) 0000, none 0001. The receive data level is reached when the FIFO holds at least RX_TRIG bytes, or when the holding byte is unread if FIFOs are off. The transmit low level means the FIFO or holding register is empty.
- R7: `irq` is high exactly while some enabled source is pending. Clearing an enable bit drops it in the cycle after the write edge.
- R8: In FIFO mode a non-empty receive FIFO with no push or pop for TO_CHARS*CHAR_CYCLES clock edges raises the time-out. Any data-port read clears it.
- R9: Reading an empty receive FIFO returns the last byte popped and leaves the FIFO count unchanged.
- R10: A data-port write to a full transmit FIFO is discarded and sets the sticky `tx_ovr` flag. Bytes already queued are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| rd | input | 1 | CPU read strobe |
| wr | input | 1 | CPU write strobe |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Read data, valid while a read strobe is high |
| bank | input | 2 | Selected register bank |
| dma_rd | input | 1 | DMA read acknowledge (data port) |
| dma_wr | input | 1 | DMA write acknowledge (data port) |
| fifo_en | input | 1 | FIFO mode select |
| ext_mode | input | 1 | Extended mode select |
| rx_push | input | 1 | Receive byte strobe from shifter |
| rx_data | input | 8 | Received byte |
| tx_pop | input | 1 | Transmit byte taken by shifter |
| tx_data | output | 8 | Next byte to transmit |
| tx_avail | output | 1 | A transmit byte is waiting |
| tx_ovr | output | 1 | Sticky transmit overrun |
| ls_evt | input | 1 | Line-status condition pending |
| ms_evt | input | 1 | Modem-status condition pending |
| irq | output | 1 | Interrupt level |
| iid | output | 4 | Interrupt identification code |

## Verification
Read data is due in the same cycle as its strobe, so the bench samples `rdata` one nanosecond after it raises the strobe at a falling edge. `tx_data`, `tx_avail`, `iid`, `irq` and `tx_ovr` follow state that the next rising edge updates. The bench therefore checks them at the falling edge that follows the stimulus. The time-out is due exactly TO_CHARS*CHAR_CYCLES rising edges after the edge that captured the last push. The bench checks it both one edge early, where it must be absent, and on that edge.

// File: rtl/uart_bank_regs.sv
module uart_bank_regs #(
  parameter int DEPTH       = 4,
  parameter int RX_TRIG     = 2,
  parameter int CHAR_CYCLES = 8,
  parameter int TO_CHARS    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [1:0] bank,
  input  logic       dma_rd,
  input  logic       dma_wr,
  input  logic       fifo_en,
  input  logic       ext_mode,
  input  logic       rx_push,
  input  logic [7:0] rx_data,
  input  logic       tx_pop,
  output logic [7:0] tx_data,
  output logic       tx_avail,
  output logic       tx_ovr,
  input  logic       ls_evt,
  input  logic       ms_evt,
  output logic       irq,
  output logic [3:0] iid
);
  localparam int AW       = $clog2(DEPTH);
  localparam int CW       = AW + 1;
  localparam int TO_LIMIT = CHAR_CYCLES * TO_CHARS;
  localparam int TW       = $clog2(TO_LIMIT + 1);

  wire bank0  = (bank == 2'd0);
  wire dp_rd  = dma_rd | (rd & bank0 & (addr == 3'd0));
  wire dp_wr  = dma_wr | (wr & bank0 & (addr == 3'd0));
  wire ier_rd = rd & bank0 & (addr == 3'd1);
  wire ier_wr = wr & bank0 & (addr == 3'd1);

  logic [7:0] ier;

  // receive side
  logic [7:0]    rxq [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic [7:0]    rhr, last_rd;
  logic          rhr_v;

  wire rx_pop = dp_rd & fifo_en & (rx_cnt != '0);
  wire rx_ins = rx_push & fifo_en & ((rx_cnt != CW'(DEPTH)) | rx_pop);

  always_ff @(posedge clk)
    if (rx_ins) rxq[rx_wp] <= rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp   <= '0;
      rx_rp   <= '0;
      rx_cnt  <= '0;
      last_rd <= '0;
      rhr     <= '0;
      rhr_v   <= 1'b0;
    end else begin
      if (rx_ins) rx_wp <= rx_wp + 1'b1;
      if (rx_pop) begin
        rx_rp   <= rx_rp + 1'b1;
        last_rd <= rxq[rx_rp];
      end
      rx_cnt <= rx_cnt + CW'(rx_ins) - CW'(rx_pop);
      if (rx_push && !fifo_en) begin
        rhr   <= rx_data;
        rhr_v <= 1'b1;
      end else if (dp_rd && !fifo_en) begin
        rhr_v <= 1'b0;
      end
    end
  end

  wire [7:0] dp_val = !fifo_en ? rhr : (rx_cnt != '0) ? rxq[rx_rp] : last_rd;

  assign rdata = dp_rd ? dp_val : ier_rd ? ier : 8'h00;

  // receive time-out
  logic [TW-1:0] idle;
  logic          to_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle    <= '0;
      to_flag <= 1'b0;
    end else begin
      if (!fifo_en || rx_cnt == '0 || rx_ins || rx_pop) idle <= '0;
      else if (idle != TW'(TO_LIMIT)) idle <= idle + 1'b1;
      if (dp_rd) to_flag <= 1'b0;
      else if (fifo_en && rx_cnt != '0 && !rx_ins && idle == TW'(TO_LIMIT - 1))
        to_flag <= 1'b1;
    end
  end

  // transmit side
  logic [7:0]    txq [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic [7:0]    thr;
  logic          thr_v;

  wire tx_full = (tx_cnt == CW'(DEPTH));
  wire tx_ins  = dp_wr & fifo_en & !tx_full;
  wire tx_rem  = tx_pop & fifo_en & (tx_cnt != '0);

  always_ff @(posedge clk)
    if (tx_ins) txq[tx_wp] <= wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
      thr    <= '0;
      thr_v  <= 1'b0;
      tx_ovr <= 1'b0;
    end else begin
      if (tx_ins) tx_wp <= tx_wp + 1'b1;
      if (tx_rem) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_ins) - CW'(tx_rem);
      if (dp_wr && fifo_en && tx_full) tx_ovr <= 1'b1;
      if (dp_wr && !fifo_en) begin
        thr   <= wdata;
        thr_v <= 1'b1;
      end else if (tx_pop && !fifo_en) begin
        thr_v <= 1'b0;
      end
    end
  end

  assign tx_data  = fifo_en ? txq[tx_rp] : thr;
  assign tx_avail = fifo_en ? (tx_cnt != '0) : thr_v;

  // interrupt enable
  always_ff @(posedge clk) begin
    if (!rst_n) ier <= 8'h00;
    else if (ier_wr) ier <= {wdata[7:4] & {4{ext_mode}}, wdata[3:0]};
    else if (!ext_mode) ier[7:4] <= 4'h0;
  end

  // interrupt sources
  wire rx_lvl = fifo_en ? (rx_cnt >= CW'(RX_TRIG)) : rhr_v;
  wire tx_low = fifo_en ? (tx_cnt == '0) : !thr_v;

  always_comb begin
    if      (ier[2] & ls_evt)  iid = 4'b0110;
    else if (ier[0] & rx_lvl)  iid = 4'b0100;
    else if (ier[0] & to_flag) iid = 4'b1100;
    else if (ier[1] & tx_low)  iid = 4'b0010;
    else if (ier[3] & ms_evt)  iid = 4'b0000;
    else                       iid = 4'b0001;
  end

  assign irq = (ier[2] & ls_evt) | (ier[0] & (rx_lvl | to_flag)) |
               (ier[1] & tx_low) | (ier[3] & ms_evt);

  // R3
  rx_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));
  // R10
  tx_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_wr && fifo_en && tx_full) |=> (tx_ovr && tx_cnt == CW'(DEPTH) - CW'($past(tx_rem))));
  // R5
  ier_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |=> ier[7:4] == 4'h0);
  // R8
  to_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_flag |-> rx_cnt != '0);
  // R6
  iid_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iid == 4'b0001) == !irq);
  // R7
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ier[3:0] != 4'h0);
  // R9
  rx_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && dp_rd && rx_cnt == '0 && !rx_push) |=> rx_cnt == '0);
endmodule

// File: tb/uart_bank_regs_tb.sv
`timescale 1ns/1ps
module uart_bank_regs_tb;
  localparam int DEPTH = 4;
  localparam int TRIG  = 2;
  localparam int LIMIT = 8 * 4;

  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic rd = 0, wr = 0, dma_rd = 0, dma_wr = 0;
  logic [7:0] wdata = 0, rdata, rx_data = 0, tx_data;
  logic [1:0] bank = 0;
  logic fifo_en = 0, ext_mode = 0, rx_push = 0, tx_pop = 0, ls_evt = 0, ms_evt = 0;
  logic tx_avail, tx_ovr, irq;
  logic [3:0] iid;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  uart_bank_regs #(.DEPTH(DEPTH), .RX_TRIG(TRIG), .CHAR_CYCLES(8), .TO_CHARS(4)) u_dut (
    .clk, .rst_n, .addr, .rd, .wr, .wdata, .rdata, .bank, .dma_rd, .dma_wr,
    .fifo_en, .ext_mode, .rx_push, .rx_data, .tx_pop, .tx_data, .tx_avail,
    .tx_ovr, .ls_evt, .ms_evt, .irq, .iid);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1; @(negedge clk); wr = 0;
  endtask
  task automatic cpu_rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd = 1; #1 d = rdata; @(negedge clk); rd = 0;
  endtask
  task automatic dmaw(input logic [7:0] d);
    wdata = d; dma_wr = 1; @(negedge clk); dma_wr = 0;
  endtask
  task automatic dmar(output logic [7:0] d);
    dma_rd = 1; #1 d = rdata; @(negedge clk); dma_rd = 0;
  endtask
  task automatic rxp(input logic [7:0] d);
    rx_data = d; rx_push = 1; @(negedge clk); rx_push = 0;
  endtask
  task automatic txp(output logic [7:0] d);
    d = tx_data; tx_pop = 1; @(negedge clk); tx_pop = 0;
  endtask

  function automatic logic [3:0] exp_iid(logic [3:0] ie, logic ls, logic lvl,
                                         logic to, logic tl, logic ms);
    if (ie[2] && ls) return 4'b0110;
    if (ie[0] && lvl) return 4'b0100;
    if (ie[0] && to) return 4'b1100;
    if (ie[1] && tl) return 4'b0010;
    if (ie[3] && ms) return 4'b0000;
    return 4'b0001;
  endfunction

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 iid", iid, 4'b0001);
    chk("R1 tx_avail", tx_avail, 0);
    chk("R1 tx_ovr", tx_ovr, 0);
    cpu_rd(1, d); chk("R1 ier", d, 8'h00);

    // R5 sweep of every enable value in both modes
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 256; v++) begin
        ext_mode = m[0];
        cpu_wr(1, v[7:0]);
        cpu_rd(1, d);
        chk("R5 ier readback", d, m ? v[7:0] : (v[7:0] & 8'h0F));
      end
    ext_mode = 1; cpu_wr(1, 8'hF0);
    ext_mode = 0; @(negedge clk);
    cpu_rd(1, d); chk("R5 upper cleared on leaving ext", d, 8'h00);

    // R2 holding registers
    cpu_wr(0, 8'h5A);
    chk("R2 tx_avail", tx_avail, 1);
    chk("R2 tx_data", tx_data, 8'h5A);
    txp(d);
    chk("R2 tx popped", tx_avail, 0);
    rxp(8'hC3);
    cpu_rd(0, d); chk("R2 rx holding", d, 8'hC3);

    // R3 FIFO order
    fifo_en = 1;
    for (int i = 0; i < DEPTH; i++) cpu_wr(0, 8'(i * 17 + 3));
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 tx avail", tx_avail, 1);
      txp(d); chk("R3 tx order", d, 8'(i * 17 + 3));
    end
    chk("R3 tx drained", tx_avail, 0);
    for (int i = 0; i < DEPTH; i++) rxp(8'(8'hA0 + i));
    for (int i = 0; i < DEPTH; i++) begin
      cpu_rd(0, d); chk("R3 rx order", d, 8'(8'hA0 + i));
    end
    // R9 empty read
    cpu_rd(0, d); chk("R9 empty read last", d, 8'hA3);
    cpu_rd(0, d); chk("R9 empty read again", d, 8'hA3);
    rxp(8'h77);
    cpu_rd(0, d); chk("R9 no underflow", d, 8'h77);

    // R10 overrun
    chk("R10 ovr clear", tx_ovr, 0);
    for (int i = 0; i <= DEPTH; i++) cpu_wr(0, 8'(8'h10 + i));
    chk("R10 ovr set", tx_ovr, 1);
    for (int i = 0; i < DEPTH; i++) begin
      txp(d); chk("R10 kept bytes", d, 8'(8'h10 + i));
    end
    chk("R10 dropped byte", tx_avail, 0);
    chk("R10 sticky", tx_ovr, 1);

    // R4 bank decoding and DMA
    bank = 2;
    cpu_wr(0, 8'h99);
    chk("R4 cpu write other bank", tx_avail, 0);
    cpu_wr(1, 8'h0F);
    dmaw(8'h3C);
    chk("R4 dma write avail", tx_avail, 1);
    chk("R4 dma write data", tx_data, 8'h3C);
    txp(d);
    rxp(8'h42);
    cpu_rd(0, d); chk("R4 cpu read other bank", d, 8'h00);
    dmar(d); chk("R4 dma read", d, 8'h42);
    bank = 0;
    cpu_rd(1, d); chk("R4 ier untouched", d, 8'h00);

    // R6/R7 sweep over enables and external sources, rx empty, tx empty
    for (int ie = 0; ie < 16; ie++)
      for (int s = 0; s < 4; s++) begin
        ls_evt = s[0]; ms_evt = s[1];
        cpu_wr(1, 8'(ie));
        chk("R6 iid sweep", iid, exp_iid(4'(ie), s[0], 0, 0, 1, s[1]));
        chk("R7 irq sweep", irq, (ie[2] & s[0]) | ie[1] | (ie[3] & s[1]));
      end
    ls_evt = 0; ms_evt = 0;
    cpu_wr(1, 8'h01);
    rxp(8'h01);
    chk("R6 below trigger", iid, 4'b0001);
    rxp(8'h02);
    chk("R6 rx level", iid, 4'b0100);
    chk("R7 irq rx level", irq, 1);
    ls_evt = 1; cpu_wr(1, 8'h05);
    chk("R6 ls beats rx", iid, 4'b0110);
    ls_evt = 0;
    cpu_wr(1, 8'h00);
    chk("R7 irq drops after clear", irq, 0);
    cpu_rd(0, d); cpu_rd(0, d);

    // R8 time-out
    cpu_wr(1, 8'h01);
    rxp(8'h55);
    repeat (LIMIT - 1) @(negedge clk);
    chk("R8 not yet", iid, 4'b0001);
    @(negedge clk);
    chk("R8 time-out iid", iid, 4'b1100);
    chk("R8 time-out irq", irq, 1);
    cpu_rd(0, d);
    chk("R8 read data", d, 8'h55);
    chk("R8 cleared by read", iid, 4'b0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule